// File: doc/BRIEF.md
# Edge-Sensing GPIO Port with Combined Interrupt

This block is a memory-mapped general-purpose I/O port for up to 32 lines. Software reaches it through a simple single-cycle register port: an address, a write strobe, write data, and read data that follows the address in the same cycle. Each line is either an output, driven from a stored value with its output enable raised, or an input. An input line is passed through a synchronizer chain before anything else looks at it.

Every rising or falling transition seen on a synchronized input line sets a sticky change bit for that line. Software clears a change bit by writing a one to it. The change bits are ANDed with a per-line enable, and any surviving bit raises one level interrupt. A shared data register reads back the level of every line and accepts new output values. Writes to it only touch the bits selected by a write-mask register. A further register holds a trigger-kind word that software may store. That word has no influence on detection, because detection always uses both edges.

Top module: `pio_edge_ctrl`

## Requirements
- R1: After reset every line is an input (pin_oe all zero), the output value register is zero, all enables and change bits are zero, the write mask (offset 0x10) reads as all implemented lines set, the kind register reads zero, and irq is low.
- R2: Bit n of the direction register (offset 0x00) set to 1 makes line n an output: pin_oe[n] is 1 and pin_out[n] carries bit n of the stored output value. A 0 makes it an input.
- R3: A read of the data register (offset 0x04) returns the stored output value on output lines and, on input lines, the pin level once it has passed the synchronizer, available by the third clock edge after the pin changes.
- R4: A write to the data register (offset 0x04) changes only the output-value bits whose write-mask bit (offset 0x10) is 1. The other bits keep their value.
- R5: Both a rising and a falling transition on an input line set that line's bit in the change register (offset 0x0C), visible by the fourth clock edge after the pin changes.
- R6: Writing 1 to a bit of the change register clears it. Writing 0 leaves it unchanged.
- R7: If an edge on a line and a write-one-to-clear of the same change bit fall in the same cycle, the bit stays set.
- R8: irq is 1 exactly when some line has both its change bit and its enable bit (offset 0x08) set.
- R9: The kind register (offset 0x14) reads back what was written, and its value has no effect on which edges set change bits.
- R10: Register bits at positions LINES and above read as zero, and writes to them are ignored.
- R11: Transitions on the pin input of a line configured as an output never set its change bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | ADDR_W | Byte address of the register being accessed |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pin_in | input | LINES | Pin levels from the pads |
| pin_out | output | LINES | Output values to the pads |
| pin_oe | output | LINES | Output enables to the pads, 1 drives |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench builds the port with LINES set to 20, so that the twelve register bits above the implemented lines exist and can be probed. That is how the zero read-back and the ignored writes of R10 become observable; at the default of 32 those bits do not exist. The synchronizer keeps its default depth of two. This fixes the pin-to-status latency the bench counts on. It also lets the bench place an edge exactly in the cycle of a clearing write to test that the event is not lost.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Register selector decoded from the byte address
  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_LVL  = 3'd1,
    SEL_IEN  = 3'd2,
    SEL_CHG  = 3'd3,
    SEL_MSK  = 3'd4,
    SEL_KIND = 3'd5,
    SEL_NONE = 3'd7
  } pio_sel_e;

  localparam logic [31:0] OFS_DIR  = 32'h00;
  localparam logic [31:0] OFS_LVL  = 32'h04;
  localparam logic [31:0] OFS_IEN  = 32'h08;
  localparam logic [31:0] OFS_CHG  = 32'h0C;
  localparam logic [31:0] OFS_MSK  = 32'h10;
  localparam logic [31:0] OFS_KIND = 32'h14;

  function automatic pio_sel_e pio_decode(input logic [31:0] addr);
    pio_sel_e s;
    case (addr)
      OFS_DIR:  s = SEL_DIR;
      OFS_LVL:  s = SEL_LVL;
      OFS_IEN:  s = SEL_IEN;
      OFS_CHG:  s = SEL_CHG;
      OFS_MSK:  s = SEL_MSK;
      OFS_KIND: s = SEL_KIND;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
  parameter int LINES  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_i,
  input  logic [LINES-1:0] dir_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] edge_o
);

  logic [STAGES-1:0][LINES-1:0] chain_q, chain_d;
  logic [LINES-1:0]             prev_q, prev_d;

  // Next state: shift the chain, remember the last synchronized level
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin_i};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  // Both-edge detection, input lines only
  assign edge_o = (chain_q[STAGES-1] ^ prev_q) & ~dir_i;

endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pio_sel_e         sel_i,
  input  logic             we_i,
  input  logic [LINES-1:0] wdata_i,
  output logic [LINES-1:0] dir_o,
  output logic [LINES-1:0] out_o,
  output logic [LINES-1:0] ien_o,
  output logic [LINES-1:0] msk_o,
  output logic [LINES-1:0] kind_o
);

  logic [LINES-1:0] dir_q, out_q, ien_q, msk_q, kind_q;
  logic [LINES-1:0] out_d;
  logic             dir_en, out_en, ien_en, msk_en, kind_en;

  always_comb begin
    dir_en  = we_i && (sel_i == SEL_DIR);
    out_en  = we_i && (sel_i == SEL_LVL);
    ien_en  = we_i && (sel_i == SEL_IEN);
    msk_en  = we_i && (sel_i == SEL_MSK);
    kind_en = we_i && (sel_i == SEL_KIND);
    out_d   = (out_q & ~msk_q) | (wdata_i & msk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      msk_q  <= '1;
      kind_q <= '0;
    end else begin
      if (dir_en)  dir_q  <= wdata_i;
      if (out_en)  out_q  <= out_d;
      if (ien_en)  ien_q  <= wdata_i;
      if (msk_en)  msk_q  <= wdata_i;
      if (kind_en) kind_q <= wdata_i;
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign ien_o  = ien_q;
  assign msk_o  = msk_q;
  assign kind_o = kind_q;

  // Unmasked output bits keep their value across a data write
  assert_masked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == SEL_LVL) |=> (((out_q ^ $past(out_q)) & ~$past(msk_q)) == '0));

endmodule

// File: rtl/pio_chg.sv
module pio_chg #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] edge_i,
  input  logic [LINES-1:0] clr_i,
  input  logic [LINES-1:0] ien_i,
  input  logic [LINES-1:0] dir_i,
  output logic [LINES-1:0] chg_o,
  output logic             irq_o
);

  logic [LINES-1:0] chg_q, chg_d;

  // A new edge wins over a clear in the same cycle
  always_comb chg_d = (chg_q & ~clr_i) | edge_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= chg_d;
  end

  assign chg_o = chg_q;
  assign irq_o = |(chg_q & ien_i);

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      edge_i[i] |=> chg_q[i]);
    assert_clear_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !edge_i[i]) |=> !chg_q[i]);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_q[i] && !clr_i[i]) |=> chg_q[i]);
    assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i[i] && clr_i[i]) |=> chg_q[i]);
    assert_output_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_i[i] && !chg_q[i]) |=> !chg_q[i]);
  end

endmodule

// File: rtl/pio_edge_ctrl.sv
module pio_edge_ctrl
  import pio_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe,
  output logic              irq
);

  pio_sel_e         sel;
  logic [LINES-1:0] wdata_l;
  logic [LINES-1:0] dir, outv, ien, msk, kind;
  logic [LINES-1:0] lvl, edges, chg, clr;
  logic [LINES-1:0] rd_l;

  always_comb begin
    sel     = pio_decode(32'(bus_addr));
    wdata_l = bus_wdata[LINES-1:0];
    clr     = (bus_we && sel == SEL_CHG) ? wdata_l : '0;
  end

  pio_regs #(.LINES(LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .we_i(bus_we), .wdata_i(wdata_l),
    .dir_o(dir), .out_o(outv), .ien_o(ien), .msk_o(msk), .kind_o(kind)
  );

  pio_in_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .dir_i(dir),
    .lvl_o(lvl), .edge_o(edges)
  );

  pio_chg #(.LINES(LINES)) u_chg (
    .clk(clk), .rst_n(rst_n), .edge_i(edges), .clr_i(clr), .ien_i(ien),
    .dir_i(dir), .chg_o(chg), .irq_o(irq)
  );

  // Read mux, upper bits zero-extended
  always_comb begin
    case (sel)
      SEL_DIR:  rd_l = dir;
      SEL_LVL:  rd_l = (dir & outv) | (~dir & lvl);
      SEL_IEN:  rd_l = ien;
      SEL_CHG:  rd_l = chg;
      SEL_MSK:  rd_l = msk;
      SEL_KIND: rd_l = kind;
      default:  rd_l = '0;
    endcase
    bus_rdata = 32'(rd_l);
  end

  assign pin_out = outv;
  assign pin_oe  = dir;

  // Enabling only lines with nothing pending, while no edge arrives, leaves irq low
  assert_quiet_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_IEN && (wdata_l & chg) == '0 && edges == '0) |=> !irq);

endmodule

// File: tb/pio_edge_ctrl_test.sv
`timescale 1ns/1ps
module pio_edge_ctrl_test;

  localparam int LINES  = 20;
  localparam int ADDR_W = 8;
  localparam logic [31:0] IMPL = 32'h000F_FFFF;

  localparam int K_RD = 0, K_IRQ = 1, K_OUT = 2, K_OE = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [LINES-1:0]  pin_in = '0;
  logic [LINES-1:0]  pin_out, pin_oe;
  logic              irq;

  sb_item_t sb[$];
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pio_edge_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      sb_item_t it;
      logic [31:0] got;
      it = sb.pop_front();
      case (it.kind)
        K_RD:    got = bus_rdata;
        K_IRQ:   got = {31'd0, irq};
        K_OUT:   got = 32'(pin_out);
        default: got = 32'(pin_oe);
      endcase
      total++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a[ADDR_W-1:0]; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [31:0] a,
                             input logic [31:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    bus_addr = a[ADDR_W-1:0];
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(posedge clk); #1;
    pin_in = v[LINES-1:0];
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_item(K_RD, 32'h00, 32'h0, "R1 dir");
    expect_item(K_RD, 32'h04, 32'h0, "R1 data");
    expect_item(K_RD, 32'h08, 32'h0, "R1 enable");
    expect_item(K_RD, 32'h0C, 32'h0, "R1 change");
    expect_item(K_RD, 32'h10, IMPL, "R1 mask");
    expect_item(K_RD, 32'h14, 32'h0, "R1 kind");
    expect_item(K_IRQ, 32'h0, 32'h0, "R1 irq");
    expect_item(K_OE, 32'h0, 32'h0, "R1 oe");

    // R2 direction and drive
    wr(32'h00, 32'h0000_00FF);
    wr(32'h04, 32'h0000_00A5);
    expect_item(K_OE, 32'h0, 32'h0000_00FF, "R2 oe");
    expect_item(K_OUT, 32'h0, 32'h0000_00A5, "R2 pin_out");
    expect_item(K_RD, 32'h04, 32'h0000_00A5, "R3 data outputs");

    // R3 and R5: input lines 8..11 rise
    set_pins(32'h0000_0F00);
    idle(4);
    expect_item(K_RD, 32'h04, 32'h0000_0FA5, "R3 data mixed");
    expect_item(K_RD, 32'h0C, 32'h0000_0F00, "R5 rise");
    // R6 partial clear
    wr(32'h0C, 32'h0000_0300);
    expect_item(K_RD, 32'h0C, 32'h0000_0C00, "R6 partial clear");
    wr(32'h0C, 32'h0000_0C00);
    expect_item(K_RD, 32'h0C, 32'h0, "R6 full clear");

    // R11 pin activity on output lines
    set_pins(32'h0000_0F0F);
    idle(4);
    expect_item(K_RD, 32'h0C, 32'h0, "R11 output lines quiet");
    expect_item(K_RD, 32'h04, 32'h0000_0FA5, "R3 outputs read driven value");

    // R4 write mask
    wr(32'h10, 32'h0000_000F);
    wr(32'h04, 32'hFFFF_FFFF);
    expect_item(K_OUT, 32'h0, 32'h0000_00AF, "R4 masked write");
    expect_item(K_RD, 32'h04, 32'h0000_0FAF, "R4 data read");
    wr(32'h10, 32'hFFFF_FFFF);
    expect_item(K_RD, 32'h10, IMPL, "R10 mask upper bits");

    // R8 combined interrupt, R5 falling edge
    wr(32'h08, 32'h0000_0100);
    expect_item(K_IRQ, 32'h0, 32'h0, "R8 enabled no change");
    set_pins(32'h0000_0E0F);
    idle(4);
    expect_item(K_RD, 32'h0C, 32'h0000_0100, "R5 fall");
    expect_item(K_IRQ, 32'h0, 32'h1, "R8 irq raised");
    wr(32'h08, 32'h0000_0200);
    expect_item(K_IRQ, 32'h0, 32'h0, "R8 other line enabled");
    wr(32'h08, 32'h0000_0100);
    expect_item(K_IRQ, 32'h0, 32'h1, "R8 re-enabled");
    wr(32'h0C, 32'h0000_0100);
    expect_item(K_IRQ, 32'h0, 32'h0, "R8 cleared");
    wr(32'h08, 32'h0);

    // R9 kind register is plain storage
    wr(32'h14, 32'hFFFF_FFFF);
    expect_item(K_RD, 32'h14, IMPL, "R9 kind readback");
    set_pins(32'h0000_0C0F);
    idle(4);
    expect_item(K_RD, 32'h0C, 32'h0000_0200, "R9 fall still sensed");
    wr(32'h0C, 32'h0000_0200);
    wr(32'h14, 32'h0);
    set_pins(32'h0000_0E0F);
    idle(4);
    expect_item(K_RD, 32'h0C, 32'h0000_0200, "R9 rise still sensed");
    wr(32'h0C, 32'h0000_0200);

    // R7 edge in the same cycle as the clearing write
    set_pins(32'h0000_0A0F);
    idle(4);
    expect_item(K_RD, 32'h0C, 32'h0000_0400, "R7 bit set first");
    @(posedge clk); #1;
    pin_in = 20'h00E0F;
    @(posedge clk);
    @(posedge clk); #1;
    bus_addr = 8'h0C; bus_wdata = 32'h0000_0400; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
    expect_item(K_RD, 32'h0C, 32'h0000_0400, "R7 edge survives clear");
    wr(32'h0C, 32'h0000_0400);
    expect_item(K_RD, 32'h0C, 32'h0, "R6 clear after R7");

    // R10 upper bits
    wr(32'h08, 32'hFFFF_FFFF);
    expect_item(K_RD, 32'h08, IMPL, "R10 enable upper bits");
    wr(32'h08, 32'h0);
    wr(32'h00, 32'hFFF0_0000);
    expect_item(K_RD, 32'h00, 32'h0, "R10 dir upper write ignored");
    expect_item(K_OE, 32'h0, 32'h0, "R10 oe after upper write");

    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule